// File: doc/BRIEF.md
# Buffered Matrix Multiply Engine

The engine multiplies two square matrices of signed 32-bit integers whose dimension is chosen at the start of each run, from 1 up to a compile-time maximum (`MAX_DIM`, at most 64). A run has three phases in strict sequence.

In the first phase both operands arrive on one valid/ready word stream, each in row-major order. The second phase computes one output element per clock. The third phase returns the product on a valid/ready output stream, also in row-major order.

The left operand is held in storage banked by column, so a whole row can be read in one cycle. The right operand is banked by row, so a whole column can be read in one cycle. Every cycle the engine forms a full `MAX_DIM`-length dot product, and unused entries are held at zero. Because of this the rate of one element per clock does not depend on the run-time dimension.

Top module: `mm_engine`

## Requirements
- R1: `dim` is captured when `start` is high while the engine is idle. `start` and `dim` have no effect while a run is in progress, up to and including the cycle in which the final output word is accepted. `start` in the cycle `done` is high begins a new run.
- R2: A word is taken when `in_valid` and `in_ready` are both high. The first dim×dim words fill the left operand in row-major order: the column advances on each word and wraps at `dim`, which advances the row. The next dim×dim words fill the right operand in the same way. `in_ready` is high only during these two loading phases.
- R3: Products and sums wrap modulo 2^32, and overflow is neither flagged nor saturated.
- R4: Both operand stores are cleared to zero at the beginning of every run, so data from an earlier run with a larger dimension never affects a result.
- R5: Output positions are computed one per clock in row-major order, with a fixed 12-cycle latency. The first `out_valid` is therefore asserted exactly dim×dim+12 cycles after the cycle in which the last right-operand word was accepted.
- R6: The result leaves as dim×dim words in row-major order. While `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged.
- R7: `done` is high for exactly one cycle, the cycle after the final output word is accepted.
- R8: Element (i,j) equals the sum over k of left(i,k)×right(k,j). The hardware sums over all `MAX_DIM` values of k, and the zero entries beyond `dim` contribute nothing.
- R9: After reset, `in_ready`, `out_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (honoured only when idle) |
| dim | input | 7 | Matrix dimension for the run, 1..MAX_DIM |
| done | output | 1 | One-cycle pulse after the last result word is accepted |
| in_valid | input | 1 | Operand word present |
| in_ready | output | 1 | Engine accepts an operand word |
| in_data | input | 32 | Operand word, signed |
| out_valid | output | 1 | Result word present |
| out_ready | input | 1 | Consumer accepts a result word |
| out_data | output | 32 | Result word, signed |

## Verification
The completion pulse and the acceptance of a new `start` can fall in the same cycle. So can the final output handshake and a `start` that must be ignored. The bench raises `start` and changes `dim` to a new value while the last result word of a run is being offered. It keeps them held into the `done` cycle, so the new run begins on the following edge. The bench then checks that the finishing run kept its own dimension and that the next run loads exactly new-dim² words per operand. That run's results also show that the clear between runs left no stale data from the larger run before it.

// File: rtl/mm_pkg.sv
package mm_pkg;
    localparam int WORD_W = 32;
    localparam int IDX_W  = 6;
    localparam int DIM_W  = 7;

    typedef logic signed [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]         idx_t;
    typedef logic [DIM_W-1:0]         dim_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_LOAD_A,
        ST_LOAD_B,
        ST_COMPUTE,
        ST_DRAIN,
        ST_WRITE
    } state_t;

    typedef struct packed {
        logic last;
        idx_t row;
        idx_t col;
    } tag_t;

    function automatic idx_t top_index(dim_t d);
        dim_t m;
        m = d - 1'b1;
        return m[IDX_W-1:0];
    endfunction
endpackage

// File: rtl/mm_rc_counter.sv
module mm_rc_counter
    import mm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    input  dim_t dim_i,
    output idx_t row_o,
    output idx_t col_o,
    output logic last_o
);
    idx_t top;
    assign top    = top_index(dim_i);
    assign last_o = (row_o == top) && (col_o == top);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            row_o <= '0;
            col_o <= '0;
        end else if (step) begin
            if (col_o == top) begin
                col_o <= '0;
                row_o <= last_o ? '0 : row_o + 1'b1;
            end else begin
                col_o <= col_o + 1'b1;
            end
        end
    end

    // R2: the column index never runs past dim-1
    p_col_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        step |-> (col_o <= top && row_o <= top));
endmodule

// File: rtl/mm_dot_pipe.sv
module mm_dot_pipe
    import mm_pkg::*;
#(
    parameter int N       = 16,
    parameter int LATENCY = 12
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  tag_t  in_tag,
    input  word_t a_vec [N],
    input  word_t b_vec [N],
    output logic  out_valid,
    output tag_t  out_tag,
    output word_t out_sum
);
    // three working stages plus padding; the store write adds the last cycle
    localparam int PAD = LATENCY - 4;

    logic  v1, v2;
    tag_t  t1, t2;
    word_t a1 [N];
    word_t b1 [N];
    word_t p2 [N];
    word_t tree_sum;

    logic  vd [PAD+1];
    tag_t  td [PAD+1];
    word_t sd [PAD+1];

    always_ff @(posedge clk) begin
        if (rst) begin
            v1    <= 1'b0;
            v2    <= 1'b0;
            vd[0] <= 1'b0;
        end else begin
            v1    <= in_valid;
            v2    <= v1;
            vd[0] <= v2;
        end
    end

    always_ff @(posedge clk) begin
        t1    <= in_tag;
        t2    <= t1;
        td[0] <= t2;
        sd[0] <= tree_sum;
        for (int k = 0; k < N; k++) begin
            a1[k] <= a_vec[k];
            b1[k] <= b_vec[k];
            p2[k] <= a1[k] * b1[k];
        end
    end

    always_comb begin
        tree_sum = '0;
        for (int k = 0; k < N; k++) tree_sum = tree_sum + p2[k];
    end

    for (genvar g = 1; g <= PAD; g++) begin : g_delay
        always_ff @(posedge clk) begin
            if (rst) vd[g] <= 1'b0;
            else     vd[g] <= vd[g-1];
            td[g] <= td[g-1];
            sd[g] <= sd[g-1];
        end
    end

    assign out_valid = vd[PAD];
    assign out_tag   = td[PAD];
    assign out_sum   = sd[PAD];
endmodule

// File: rtl/mm_engine.sv
module mm_engine
    import mm_pkg::*;
#(
    parameter int MAX_DIM = 16,
    parameter int LATENCY = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [DIM_W-1:0]    dim,
    output logic                done,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [WORD_W-1:0]   in_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [WORD_W-1:0]   out_data
);
    localparam int AW = (MAX_DIM > 1) ? $clog2(MAX_DIM) : 1;

    state_t state;
    dim_t   dim_q;

    word_t a_buf [MAX_DIM][MAX_DIM];
    word_t b_buf [MAX_DIM][MAX_DIM];
    word_t c_buf [MAX_DIM][MAX_DIM];

    idx_t io_row, io_col, is_row, is_col;
    logic io_last, is_last, io_step, issue;

    word_t a_row [MAX_DIM];
    word_t b_col [MAX_DIM];
    tag_t  is_tag, res_tag;
    logic  res_valid;
    word_t res_sum;

    assign in_ready  = (state == ST_LOAD_A) || (state == ST_LOAD_B);
    assign out_valid = (state == ST_WRITE);
    assign io_step   = (in_valid && in_ready) || (out_valid && out_ready);
    assign issue     = (state == ST_COMPUTE);
    assign out_data  = c_buf[io_row[AW-1:0]][io_col[AW-1:0]];

    mm_rc_counter u_io_ctr (
        .clk(clk), .rst(rst), .clr(state == ST_CLEAR), .step(io_step),
        .dim_i(dim_q), .row_o(io_row), .col_o(io_col), .last_o(io_last)
    );

    mm_rc_counter u_issue_ctr (
        .clk(clk), .rst(rst), .clr(state == ST_CLEAR), .step(issue),
        .dim_i(dim_q), .row_o(is_row), .col_o(is_col), .last_o(is_last)
    );

    always_comb begin
        for (int k = 0; k < MAX_DIM; k++) begin
            a_row[k] = a_buf[is_row[AW-1:0]][k];
            b_col[k] = b_buf[k][is_col[AW-1:0]];
        end
        is_tag = '{last: is_last, row: is_row, col: is_col};
    end

    mm_dot_pipe #(.N(MAX_DIM), .LATENCY(LATENCY)) u_pipe (
        .clk(clk), .rst(rst), .in_valid(issue), .in_tag(is_tag),
        .a_vec(a_row), .b_vec(b_col),
        .out_valid(res_valid), .out_tag(res_tag), .out_sum(res_sum)
    );

    always_ff @(posedge clk) begin
        if (state == ST_CLEAR) begin
            for (int r = 0; r < MAX_DIM; r++)
                for (int c = 0; c < MAX_DIM; c++) begin
                    a_buf[r][c] <= '0;
                    b_buf[r][c] <= '0;
                end
        end else if (in_valid && in_ready) begin
            if (state == ST_LOAD_A) a_buf[io_row[AW-1:0]][io_col[AW-1:0]] <= in_data;
            else                    b_buf[io_row[AW-1:0]][io_col[AW-1:0]] <= in_data;
        end
        if (res_valid)
            c_buf[res_tag.row[AW-1:0]][res_tag.col[AW-1:0]] <= res_sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            dim_q <= dim_t'(1);
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE:    if (start) begin
                                dim_q <= dim;
                                state <= ST_CLEAR;
                            end
                ST_CLEAR:   state <= ST_LOAD_A;
                ST_LOAD_A:  if (io_step && io_last) state <= ST_LOAD_B;
                ST_LOAD_B:  if (io_step && io_last) state <= ST_COMPUTE;
                ST_COMPUTE: if (is_last) state <= ST_DRAIN;
                ST_DRAIN:   if (res_valid && res_tag.last) state <= ST_WRITE;
                ST_WRITE:   if (io_step && io_last) begin
                                state <= ST_IDLE;
                                done  <= 1'b1;
                            end
                default:    state <= ST_IDLE;
            endcase
        end
    end

    // R1: the captured dimension holds for the whole run
    p_dim_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> (dim_q == $past(dim_q)));

    // R5: results only land while computing or draining
    p_result_window_r5: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (state == ST_COMPUTE || state == ST_DRAIN));

    // R6: an offered result word is held until taken
    p_out_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R7: completion is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2: input and output streams never open together
    p_one_stream_r2: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !out_valid);
endmodule

// File: tb/mm_engine_tb_top.sv
module mm_engine_tb_top;
    localparam int MAXD = 16;
    localparam int LAT  = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [6:0]  dim = 7'd1;
    logic        done;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;

    int checks = 0;
    int errors = 0;
    bit prev_done = 1'b0;

    always #10 clk = ~clk;

    mm_engine #(.MAX_DIM(MAXD), .LATENCY(LAT)) dut_i (
        .clk(clk), .rst(rst), .start(start), .dim(dim), .done(done),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // every-clock comparison of stream exclusivity and pulse width
    always @(negedge clk) begin
        if (!rst) begin
            chk(!(in_ready && out_valid), "R2", "streams overlap", in_ready, 0);
            chk(!(done && prev_done), "R7", "done wider than one cycle", 2, 1);
            prev_done = done;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    function automatic int gen(int pat, int which, int idx);
        case (pat)
            0:       return idx + 1 + which * 3;
            1:       return 32'h7fff_fff0 + idx * 977 + which;
            default: return (idx % 5) - 2 - which * 7;
        endcase
    endfunction

    task automatic send(input int w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic run(input int d, input int pat, input bit pre_started,
                       input bit chain, input int next_d, input bit poke);
        int A[];
        int B[];
        int cnt;
        A = new[d * d];
        B = new[d * d];
        for (int n = 0; n < d * d; n++) begin
            A[n] = gen(pat, 0, n);
            B[n] = gen(pat, 1, n);
        end
        if (!pre_started) begin
            @(negedge clk);
            dim = 7'(d);
            start = 1'b1;
            @(posedge clk);
            #1 start = 1'b0;
        end
        for (int n = 0; n < d * d; n++) begin
            send(A[n]);
            if (poke && n == 1) begin
                // R1: start with another dim during loading is ignored
                @(negedge clk);
                start = 1'b1;
                dim = 7'd3;
                @(posedge clk);
                #1 start = 1'b0;
            end
        end
        for (int n = 0; n < d * d; n++) send(B[n]);
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!out_valid && cnt < 2000);
        chk(cnt == d * d + LAT, "R5", "cycles to first result", cnt, d * d + LAT);
        for (int n = 0; n < d * d; n++) begin
            int i = n / d;
            int j = n % d;
            int e = 0;
            for (int k = 0; k < d; k++) e += A[i * d + k] * B[k * d + j];
            if (n % 3 == 1) begin
                out_ready = 1'b0;
                @(negedge clk);
                chk(out_valid, "R6", "valid dropped while stalled", out_valid, 1);
            end
            out_ready = 1'b1;
            if (chain && n == d * d - 1) begin
                start = 1'b1;
                dim = 7'(next_d);
            end
            chk(out_valid, "R6", "result word missing", out_valid, 1);
            chk(int'(out_data) == e, (pat == 1) ? "R3" : "R8", "result element",
                int'(out_data), e);
            @(posedge clk);
            #1 out_ready = 1'b0;
            @(negedge clk);
        end
        chk(done == 1'b1, "R7", "done after last word", done, 1);
        chk(!out_valid, "R6", "extra result word", out_valid, 0);
        if (chain) begin
            @(posedge clk);
            #1 start = 1'b0;
        end
        @(negedge clk);
        chk(done == 1'b0, "R7", "done second cycle", done, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!in_ready, "R9", "in_ready after reset", in_ready, 0);
        chk(!out_valid, "R9", "out_valid after reset", out_valid, 0);
        chk(!done, "R9", "done after reset", done, 0);
        run(1, 0, 1'b0, 1'b0, 0, 1'b0);
        run(4, 1, 1'b0, 1'b0, 0, 1'b1);
        run(MAXD, 2, 1'b0, 1'b1, 3, 1'b0);
        // R1 and R4: chained run with the new dim, after a larger run
        run(3, 0, 1'b1, 1'b0, 0, 1'b0);
        run(2, 2, 1'b0, 1'b0, 0, 1'b0);
        repeat (3) @(negedge clk);
        chk(!in_ready && !out_valid, "R2", "idle after last run", in_ready, 0);
        finish_up();
    end
endmodule